// File: doc/BRIEF.md
# Sequencer Stack Unit

This block holds the four hardware stacks of a program sequencer: a return-address stack (16 entries by default), a loop stack holding end address and termination code (4 entries), a counter stack for saved down-counter values (4 entries), and a status stack that saves the arithmetic status, mode status and interrupt mask as one frame (4 entries). It also produces an 8-bit stack status byte with an empty flag and a sticky overflow flag for each stack.

The sequencer pushes return addresses, loop descriptors and counter values through dedicated push inputs. A one-cycle stack-control command can pop any mix of the four stacks and push or pop the status frame. A popped counter value is handed to the down counter, and a popped status frame is handed back to the three status registers. Return and loop pops discard their data. A special move port writes a register value onto the return-address stack at once, or reads the top entry and removes it one cycle later.

Top module: `seq_stack_unit`

## Requirements
- R1: After reset every stack is empty, `stk_status` reads 8'h55, and `cntr_load_en` and `sts_restore_en` are low.
- R2: `stk_status` bits are: 7 loop overflow, 6 loop empty, 5 status overflow, 4 status empty, 3 counter overflow, 2 counter empty, 1 return-address overflow, 0 return-address empty.
- R3: A single command cycle pops any combination of the return-address, loop, counter and status stacks. Every selected stack loses one entry at the same clock edge.
- R4: A status push stores `{imask_in, mstat_in, astat_in}` as one frame. A status pop on a non-empty stack raises `sts_restore_en` in the same cycle and drives the top frame on `astat_out`, `mstat_out` and `imask_out`.
- R5: A counter pop on a non-empty stack raises `cntr_load_en` in that cycle with the top value on `cntr_load_val`. Return-address and loop pops only remove the entry, and `pc_top`/`loop_top` then show the entry below.
- R6: An empty flag is 1 exactly when its stack holds no entry. Any push clears it, and a pop that removes the last entry sets it.
- R7: A push onto a full stack without a pop of the same stack drops the data, leaves the stack unchanged and sets that stack's overflow flag. Overflow flags stay set through later pops and pushes until reset.
- R8: A pop of an empty stack changes nothing: the depth stays zero, the empty flag stays 1, and no load or restore strobe is given.
- R9: `tos_wr_en` pushes `tos_wr_data` onto the return-address stack at the next clock edge, and `pc_top` shows it in the following cycle.
- R10: While `tos_rd_en` is high, `tos_rd_data` shows the current return-address top. The entry is popped at the second clock edge after the read, one cycle later than a command pop. If a command pop falls in that same cycle, only one entry is removed.
- R11: A push and a pop of the same non-empty stack in one cycle replace the top entry and keep the depth. On an empty stack the pair acts as a plain push. A full stack with a pop never overflows.
- R12: When `call_push_en` and `tos_wr_en` are both high, only one return-address entry is pushed, and it holds `tos_wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_push_en | input | 1 | Push a return address (call, loop start) |
| call_push_pc | input | PC_W | Return address to push |
| loop_push_en | input | 1 | Push a loop descriptor |
| loop_push_val | input | LOOP_W | Loop end address and termination code |
| cnt_push_en | input | 1 | Push the down-counter value |
| cnt_push_val | input | CNT_W | Counter value to push |
| cmd_pop_pc | input | 1 | Command: pop return-address stack |
| cmd_pop_loop | input | 1 | Command: pop loop stack |
| cmd_pop_cnt | input | 1 | Command: pop counter stack into down counter |
| cmd_sts_push | input | 1 | Command: push status frame |
| cmd_sts_pop | input | 1 | Command: pop status frame |
| astat_in | input | 8 | Arithmetic status to save |
| mstat_in | input | 7 | Mode status to save |
| imask_in | input | 10 | Interrupt mask to save |
| tos_wr_en | input | 1 | Special move: push register onto return-address stack |
| tos_wr_data | input | PC_W | Value for the special push |
| tos_rd_en | input | 1 | Special move: read return-address top, pop one cycle later |
| tos_rd_data | output | PC_W | Return-address top for the special read |
| pc_top | output | PC_W | Current return-address top (0 when empty) |
| loop_top | output | LOOP_W | Current loop descriptor top (0 when empty) |
| cntr_load_en | output | 1 | Down counter load strobe |
| cntr_load_val | output | CNT_W | Value to load into the down counter |
| sts_restore_en | output | 1 | Status registers restore strobe |
| astat_out | output | 8 | Restored arithmetic status |
| mstat_out | output | 7 | Restored mode status |
| imask_out | output | 10 | Restored interrupt mask |
| stk_status | output | 8 | Empty and overflow flags of all four stacks |

## Verification
The hardest state to reach is the delayed special-read pop on the 16-deep return-address stack when it coincides with a command pop, a fresh push or a full stack. Random traffic that pushes and pops with equal weight rarely fills the stack. The stimulus therefore runs in phases with a push bias above and below one half, so the stacks are driven to full, held at overflow and drained past empty. Directed sequences add the overlap of a delayed pop with a command pop and with a write.

// File: rtl/seq_stack_pkg.sv
package seq_stack_pkg;
  localparam int ASTAT_W = 8;
  localparam int MSTAT_W = 7;
  localparam int IMASK_W = 10;
  localparam int FRAME_W = ASTAT_W + MSTAT_W + IMASK_W;

  typedef struct packed {
    logic [IMASK_W-1:0] imask;
    logic [MSTAT_W-1:0] mstat;
    logic [ASTAT_W-1:0] astat;
  } sts_frame_t;

  typedef enum logic [1:0] {
    STK_PC   = 2'd0,
    STK_LOOP = 2'd1,
    STK_CNT  = 2'd2,
    STK_STS  = 2'd3
  } stk_id_e;
endpackage

// File: rtl/seq_stack_lifo.sv
module seq_stack_lifo #(
  parameter int W     = 14,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         ovf_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0] count_q, count_d;
  logic          ovf_q, ovf_d;
  logic [W-1:0]  mem_q [DEPTH];

  logic          is_empty, is_full;
  logic          do_replace, do_push, do_pop, ovf_evt;
  logic          wr_en;
  logic [CW-1:0] top_idx, wr_idx;

  assign is_empty = (count_q == '0);
  assign is_full  = (count_q == FULL_CNT);
  assign top_idx  = count_q - CW'(1);

  always_comb begin
    do_replace = push_i && pop_i && !is_empty;
    do_push    = push_i && !do_replace && !is_full;
    do_pop     = pop_i && !push_i && !is_empty;
    ovf_evt    = push_i && !do_replace && is_full;

    count_d = count_q;
    if (do_push)     count_d = count_q + CW'(1);
    else if (do_pop) count_d = top_idx;

    ovf_d = ovf_q | ovf_evt;

    wr_en  = do_push | do_replace;
    wr_idx = do_replace ? top_idx : count_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      ovf_q   <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx[IW-1:0]] <= data_i;
  end

  assign top_o   = is_empty ? '0 : mem_q[top_idx[IW-1:0]];
  assign empty_o = is_empty;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/seq_tos_port.sv
module seq_tos_port #(
  parameter int PC_W = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            call_push_i,
  input  logic [PC_W-1:0] call_data_i,
  input  logic            tos_wr_i,
  input  logic [PC_W-1:0] tos_wr_data_i,
  input  logic            tos_rd_i,
  input  logic            cmd_pop_i,
  output logic            push_o,
  output logic [PC_W-1:0] push_data_o,
  output logic            pop_o
);
  logic rd_pend_q, rd_pend_d;

  assign rd_pend_d = tos_rd_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_pend_q <= 1'b0;
    else        rd_pend_q <= rd_pend_d;
  end

  always_comb begin
    push_o      = call_push_i | tos_wr_i;
    push_data_o = tos_wr_i ? tos_wr_data_i : call_data_i;
    pop_o       = cmd_pop_i | rd_pend_q;
  end
endmodule

// File: rtl/seq_stack_unit.sv
module seq_stack_unit
  import seq_stack_pkg::*;
#(
  parameter int PC_W       = 14,
  parameter int LOOP_W     = 18,
  parameter int CNT_W      = 14,
  parameter int PC_DEPTH   = 16,
  parameter int LOOP_DEPTH = 4,
  parameter int CNT_DEPTH  = 4,
  parameter int STS_DEPTH  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               call_push_en,
  input  logic [PC_W-1:0]    call_push_pc,
  input  logic               loop_push_en,
  input  logic [LOOP_W-1:0]  loop_push_val,
  input  logic               cnt_push_en,
  input  logic [CNT_W-1:0]   cnt_push_val,
  input  logic               cmd_pop_pc,
  input  logic               cmd_pop_loop,
  input  logic               cmd_pop_cnt,
  input  logic               cmd_sts_push,
  input  logic               cmd_sts_pop,
  input  logic [ASTAT_W-1:0] astat_in,
  input  logic [MSTAT_W-1:0] mstat_in,
  input  logic [IMASK_W-1:0] imask_in,
  input  logic               tos_wr_en,
  input  logic [PC_W-1:0]    tos_wr_data,
  input  logic               tos_rd_en,
  output logic [PC_W-1:0]    tos_rd_data,
  output logic [PC_W-1:0]    pc_top,
  output logic [LOOP_W-1:0]  loop_top,
  output logic               cntr_load_en,
  output logic [CNT_W-1:0]   cntr_load_val,
  output logic               sts_restore_en,
  output logic [ASTAT_W-1:0] astat_out,
  output logic [MSTAT_W-1:0] mstat_out,
  output logic [IMASK_W-1:0] imask_out,
  output logic [7:0]         stk_status
);
  logic            pc_push, pc_pop;
  logic [PC_W-1:0] pc_push_data;
  logic            pc_empty, pc_ovf;
  logic            loop_empty, loop_ovf;
  logic            cnt_empty, cnt_ovf;
  logic            sts_empty, sts_ovf;
  logic [CNT_W-1:0] cnt_top;
  sts_frame_t      sts_in, sts_top;

  seq_tos_port #(.PC_W(PC_W)) u_tos (
    .clk           (clk),
    .rst_n         (rst_n),
    .call_push_i   (call_push_en),
    .call_data_i   (call_push_pc),
    .tos_wr_i      (tos_wr_en),
    .tos_wr_data_i (tos_wr_data),
    .tos_rd_i      (tos_rd_en),
    .cmd_pop_i     (cmd_pop_pc),
    .push_o        (pc_push),
    .push_data_o   (pc_push_data),
    .pop_o         (pc_pop)
  );

  seq_stack_lifo #(.W(PC_W), .DEPTH(PC_DEPTH)) u_pc_stk (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (pc_push),
    .pop_i   (pc_pop),
    .data_i  (pc_push_data),
    .top_o   (pc_top),
    .empty_o (pc_empty),
    .ovf_o   (pc_ovf)
  );

  seq_stack_lifo #(.W(LOOP_W), .DEPTH(LOOP_DEPTH)) u_loop_stk (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (loop_push_en),
    .pop_i   (cmd_pop_loop),
    .data_i  (loop_push_val),
    .top_o   (loop_top),
    .empty_o (loop_empty),
    .ovf_o   (loop_ovf)
  );

  seq_stack_lifo #(.W(CNT_W), .DEPTH(CNT_DEPTH)) u_cnt_stk (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (cnt_push_en),
    .pop_i   (cmd_pop_cnt),
    .data_i  (cnt_push_val),
    .top_o   (cnt_top),
    .empty_o (cnt_empty),
    .ovf_o   (cnt_ovf)
  );

  always_comb begin
    sts_in.imask = imask_in;
    sts_in.mstat = mstat_in;
    sts_in.astat = astat_in;
  end

  seq_stack_lifo #(.W(FRAME_W), .DEPTH(STS_DEPTH)) u_sts_stk (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (cmd_sts_push),
    .pop_i   (cmd_sts_pop),
    .data_i  (sts_in),
    .top_o   (sts_top),
    .empty_o (sts_empty),
    .ovf_o   (sts_ovf)
  );

  always_comb begin
    tos_rd_data    = pc_top;
    cntr_load_en   = cmd_pop_cnt && !cnt_empty;
    cntr_load_val  = cnt_top;
    sts_restore_en = cmd_sts_pop && !sts_empty;
    astat_out      = sts_top.astat;
    mstat_out      = sts_top.mstat;
    imask_out      = sts_top.imask;
    stk_status     = {loop_ovf, loop_empty, sts_ovf, sts_empty,
                      cnt_ovf, cnt_empty, pc_ovf, pc_empty};
  end
endmodule

// File: rtl/seq_stack_unit_chk.sv
module seq_stack_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       call_push_en,
  input logic       tos_wr_en,
  input logic       loop_push_en,
  input logic       cnt_push_en,
  input logic       cmd_sts_push,
  input logic       cntr_load_en,
  input logic       sts_restore_en,
  input logic [7:0] stk_status
);
  AST_PC_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stk_status[1] |=> stk_status[1]); // R7
  AST_LOOP_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stk_status[7] |=> stk_status[7]); // R7
  AST_CNT_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stk_status[3] |=> stk_status[3]); // R7
  AST_STS_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stk_status[5] |=> stk_status[5]); // R7
  AST_PC_OVF_NEEDS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (!stk_status[1] && !call_push_en && !tos_wr_en) |=> !stk_status[1]); // R7
  AST_PC_PUSH_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (call_push_en || tos_wr_en) |=> !stk_status[0]); // R9
  AST_LOOP_PUSH_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    loop_push_en |=> !stk_status[6]); // R6
  AST_CNT_PUSH_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_push_en |=> !stk_status[2]); // R6
  AST_STS_PUSH_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_sts_push |=> !stk_status[4]); // R4
  AST_LOAD_ONLY_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    cntr_load_en |-> !stk_status[2]); // R8
  AST_RESTORE_ONLY_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    sts_restore_en |-> !stk_status[4]); // R8
endmodule

bind seq_stack_unit seq_stack_unit_chk u_chk (.*);

// File: tb/seq_stack_unit_bench.sv
`timescale 1ns/1ps
module seq_stack_unit_bench;
  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic        call_push_en, loop_push_en, cnt_push_en, tos_wr_en, tos_rd_en;
  logic [13:0] call_push_pc, cnt_push_val, tos_wr_data;
  logic [17:0] loop_push_val;
  logic        cmd_pop_pc, cmd_pop_loop, cmd_pop_cnt, cmd_sts_push, cmd_sts_pop;
  logic [7:0]  astat_in;
  logic [6:0]  mstat_in;
  logic [9:0]  imask_in;
  logic [13:0] tos_rd_data, pc_top, cntr_load_val;
  logic [17:0] loop_top;
  logic        cntr_load_en, sts_restore_en;
  logic [7:0]  astat_out;
  logic [6:0]  mstat_out;
  logic [9:0]  imask_out;
  logic [7:0]  stk_status;

  seq_stack_unit u_seq_stack_unit (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // model: 0 return-address, 1 loop, 2 counter, 3 status
  logic [31:0] m_mem [4][16];
  int          m_cnt [4];
  bit          m_ovf [4];
  int          m_dep [4] = '{16, 4, 4, 4};
  bit          m_pend;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_top(int s);
    return (m_cnt[s] > 0) ? m_mem[s][m_cnt[s]-1] : 32'h0;
  endfunction

  function automatic logic [7:0] m_status();
    return {m_ovf[1], m_cnt[1] == 0, m_ovf[3], m_cnt[3] == 0,
            m_ovf[2], m_cnt[2] == 0, m_ovf[0], m_cnt[0] == 0};
  endfunction

  task automatic m_step(int s, bit push, bit pop, logic [31:0] d);
    if (push && pop && m_cnt[s] > 0) m_mem[s][m_cnt[s]-1] = d;
    else if (push) begin
      if (m_cnt[s] == m_dep[s]) m_ovf[s] = 1'b1;
      else begin m_mem[s][m_cnt[s]] = d; m_cnt[s]++; end
    end else if (pop && m_cnt[s] > 0) m_cnt[s]--;
  endtask

  task automatic idle_in();
    {call_push_en, loop_push_en, cnt_push_en, tos_wr_en, tos_rd_en} = '0;
    {cmd_pop_pc, cmd_pop_loop, cmd_pop_cnt, cmd_sts_push, cmd_sts_pop} = '0;
    call_push_pc = '0; cnt_push_val = '0; tos_wr_data = '0; loop_push_val = '0;
    astat_in = '0; mstat_in = '0; imask_in = '0;
  endtask

  task automatic m_reset();
    for (int s = 0; s < 4; s++) begin m_cnt[s] = 0; m_ovf[s] = 1'b0; end
    m_pend = 1'b0;
  endtask

  // inputs already driven (after a negedge); check outputs, then clock
  task automatic step();
    bit pc_push;
    logic [31:0] pc_d, frame;
    #1;
    chk("R2 status", {24'h0, stk_status}, {24'h0, m_status()});
    chk("R9 pc_top", {18'h0, pc_top}, m_top(0));
    chk("R5 loop_top", {14'h0, loop_top}, m_top(1));
    if (tos_rd_en) chk("R10 tos read", {18'h0, tos_rd_data}, m_top(0));
    chk("R5 load_en", {31'h0, cntr_load_en}, {31'h0, cmd_pop_cnt && m_cnt[2] > 0});
    if (cmd_pop_cnt && m_cnt[2] > 0)
      chk("R5 load_val", {18'h0, cntr_load_val}, m_top(2));
    chk("R4 restore_en", {31'h0, sts_restore_en}, {31'h0, cmd_sts_pop && m_cnt[3] > 0});
    if (cmd_sts_pop && m_cnt[3] > 0)
      chk("R4 frame", {7'h0, imask_out, mstat_out, astat_out}, m_top(3));
    @(posedge clk);
    pc_push = call_push_en | tos_wr_en;
    pc_d    = tos_wr_en ? {18'h0, tos_wr_data} : {18'h0, call_push_pc};
    frame   = {7'h0, imask_in, mstat_in, astat_in};
    m_step(0, pc_push, cmd_pop_pc | m_pend, pc_d);
    m_pend = tos_rd_en;
    m_step(1, loop_push_en, cmd_pop_loop, {14'h0, loop_push_val});
    m_step(2, cnt_push_en, cmd_pop_cnt, {18'h0, cnt_push_val});
    m_step(3, cmd_sts_push, cmd_sts_pop, frame);
    @(negedge clk);
  endtask

  task automatic settle();
    idle_in(); step(); step();
    chk("R2 settle", {24'h0, stk_status}, {24'h0, m_status()});
  endtask

  task automatic do_reset();
    idle_in();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_reset();
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    int pb;
    void'($urandom(32'h5eed_1234));
    do_reset();
    // R1 reset state
    #1;
    chk("R1 reset status", {24'h0, stk_status}, 32'h55);
    chk("R1 reset load", {31'h0, cntr_load_en}, 32'h0);
    chk("R1 reset restore", {31'h0, sts_restore_en}, 32'h0);

    // R8 pops on empty stacks
    idle_in(); cmd_pop_pc = 1; cmd_pop_loop = 1; cmd_pop_cnt = 1; cmd_sts_pop = 1;
    step(); idle_in(); step();
    chk("R8 empty pop", {24'h0, stk_status}, 32'h55);

    // R9 fill return stack with special writes, then one more: R7 overflow
    for (int i = 0; i < 17; i++) begin
      idle_in(); tos_wr_en = 1; tos_wr_data = 14'(16'h100 + i); step();
    end
    idle_in(); step();
    chk("R7 pc overflow", {31'h0, stk_status[1]}, 32'h1);
    chk("R7 data dropped", {18'h0, pc_top}, 32'h10f);
    // R11 full stack with push+pop replaces, no extra state
    idle_in(); call_push_en = 1; call_push_pc = 14'h2aa; cmd_pop_pc = 1; step();
    idle_in(); step();
    chk("R11 replace", {18'h0, pc_top}, 32'h2aa);

    // R10 delayed pop overlapping a command pop: only one entry removed
    idle_in(); tos_rd_en = 1; step();
    idle_in(); cmd_pop_pc = 1; step();
    idle_in(); step();
    chk("R10 single pop", {18'h0, pc_top}, 32'h10e);
    // R7 sticky through pops to empty
    for (int i = 0; i < 20; i++) begin idle_in(); cmd_pop_pc = 1; step(); end
    idle_in(); step();
    chk("R7 sticky", {30'h0, stk_status[1:0]}, 32'h3);
    // R11 push+pop on empty acts as push
    idle_in(); call_push_en = 1; call_push_pc = 14'h33; cmd_pop_pc = 1; step();
    idle_in(); step();
    chk("R11 empty pair", {18'h0, pc_top}, 32'h33);
    // R12 both push sources
    idle_in(); call_push_en = 1; call_push_pc = 14'h11; tos_wr_en = 1; tos_wr_data = 14'h22; step();
    idle_in(); step();
    chk("R12 tos wins", {18'h0, pc_top}, 32'h22);
    idle_in(); cmd_pop_pc = 1; step(); idle_in(); step();
    chk("R12 one push", {18'h0, pc_top}, 32'h33);

    // R3 combined pop of all four stacks
    do_reset();
    idle_in(); call_push_en = 1; call_push_pc = 14'h5; loop_push_en = 1; loop_push_val = 18'h3_0001;
    cnt_push_en = 1; cnt_push_val = 14'h77; cmd_sts_push = 1;
    astat_in = 8'ha5; mstat_in = 7'h3c; imask_in = 10'h2f1; step();
    idle_in(); step();
    chk("R6 all pushed", {24'h0, stk_status}, 32'h00);
    idle_in(); cmd_pop_pc = 1; cmd_pop_loop = 1; cmd_pop_cnt = 1; cmd_sts_pop = 1; step();
    idle_in(); step();
    chk("R3 all popped", {24'h0, stk_status}, 32'h55);

    // random phases with push bias
    do_reset();
    for (int ph = 0; ph < 8; ph++) begin
      pb = (ph % 2 == 0) ? 75 : 25;
      for (int c = 0; c < 400; c++) begin
        idle_in();
        call_push_en  = ($urandom % 100) < pb / 2;
        tos_wr_en     = ($urandom % 100) < pb / 3;
        tos_rd_en     = ($urandom % 100) < 15;
        cmd_pop_pc    = ($urandom % 100) < (100 - pb) / 2;
        loop_push_en  = ($urandom % 100) < pb / 2;
        cmd_pop_loop  = ($urandom % 100) < (100 - pb) / 2;
        cnt_push_en   = ($urandom % 100) < pb / 2;
        cmd_pop_cnt   = ($urandom % 100) < (100 - pb) / 2;
        cmd_sts_push  = ($urandom % 100) < pb / 2;
        cmd_sts_pop   = ($urandom % 100) < (100 - pb) / 2;
        call_push_pc  = 14'($urandom);
        tos_wr_data   = 14'($urandom);
        loop_push_val = 18'($urandom);
        cnt_push_val  = 14'($urandom);
        astat_in = 8'($urandom); mstat_in = 7'($urandom); imask_in = 10'($urandom);
        step();
      end
      if (ph == 3) begin settle(); do_reset(); end
    end
    settle();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule